// File: doc/BRIEF.md
# Tolerant Ethernet Preamble Stripper

This block sits on the receive path between a PHY-side byte stream and a frame parser. It removes the run of preamble bytes and the start-of-frame delimiter from every incoming frame, then forwards only the frame body, flagging its first and final beats. It does not count preamble bytes. Any number of them, including none and including more than the usual seven, may come before the delimiter, and the frame is opened on the delimiter alone. This tolerates links that shrink the preamble, for example by dropping a single leading byte when a transmission begins on an odd symbol position.

The datapath is one or two bytes wide (`LANES` = 1 or 2). On the 16-bit datapath the delimiter may arrive in either byte lane. When it lands in the lower lane, the block keeps one body byte in a hold register so that each output word still carries two consecutive body bytes. It then closes the frame with a half-filled word whose byte enable marks only the lower lane. Input and output are valid/data/last streams with an error flag; an error ends the output frame early.

Top module: `preamble_strip`

## Requirements
- R1: While reset is asserted, and after it is released with no input, `out_valid` stays low.
- R2: A run of 0x55 bytes of any length, including runs longer than seven, followed by 0xD5, is discarded; only the bytes after 0xD5 up to `in_last` are forwarded, in order and unchanged.
- R3: A frame whose very first byte is 0xD5 (no preamble at all) is accepted and its body forwarded.
- R4: Odd preamble lengths are accepted on both datapath widths; no even count is assumed.
- R5: Before the delimiter, a byte equal to neither 0x55 nor 0xD5 makes the block discard the rest of that input frame, with no output, until `in_last`; bytes that merely share bits with the patterns (0xD7, 0x5D) count as mismatches.
- R6: 16-bit datapath, delimiter in the upper lane (bits 15:8): the body starts at the next word, and every output word holds the earlier byte in bits 7:0 with both byte enables set.
- R7: 16-bit datapath, delimiter in the lower lane (bits 7:0): output words are realigned so that bits 7:0 hold the earlier body byte; an odd body length ends with a word whose `out_be` is 2'b01, and only a final word may be partial.
- R8: `out_sof` is high on the first body beat of a frame only; `out_eof` is high on the final beat only.
- R9: An input beat with `in_err` high inside the body is forwarded and ends the output frame with `out_eof` and `out_err` high; the remaining input beats of that frame produce no output. An error seen before any body byte produces no output.
- R10: Frames may follow each other with no idle cycle; the closing half-word of a realigned frame is emitted while the next frame's first word is consumed, and both frames come out intact.
- R11: Idle cycles (`in_valid` low) anywhere inside a frame do not alter the forwarded bytes or flags.
- R12: A frame that ends (`in_last`) before any delimiter produces no output, and the block is ready for the next frame on the following beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input beat valid |
| in_data | input | 8*LANES | Input bytes, bits 7:0 earliest on the wire |
| in_last | input | 1 | Final beat of the input frame |
| in_err | input | 1 | Receive error on this beat |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 8*LANES | Body bytes, bits 7:0 earliest |
| out_be | output | LANES | Byte enable per lane |
| out_sof | output | 1 | First body beat |
| out_eof | output | 1 | Final body beat |
| out_err | output | 1 | Frame ended by an error |

## Verification
The two functions that can meet in one cycle are the closing half-word of a realigned frame and the opening of the frame that follows it, since both use the hold register and the start flag. The bench provokes the meeting by sending frames back to back with no idle cycle, where each frame puts its delimiter in the lower lane, including one-byte bodies that reach the closing step at once. It then checks that the old hold byte, with its start and error flags, reaches the output while the new frame's first body byte is captured. A behavioural model parses each raw byte stream on its own and predicts the exact beats, byte enables and flags.

// File: rtl/pstrip_pkg.sv
package pstrip_pkg;

  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_BODY = 2'd2,
    ST_DROP = 2'd3
  } pstrip_state_e;

endpackage

// File: rtl/pstrip_rst_sync.sv
module pstrip_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pstrip_lane_match.sv
module pstrip_lane_match
  import pstrip_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic               valid,
  input  logic [8*LANES-1:0] data,
  output logic [LANES-1:0]   is_pre,
  output logic [LANES-1:0]   is_sfd
);

  // Strobe is combined with a complete byte comparison per lane.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign is_pre[g] = valid & (data[8*g +: 8] == PRE_BYTE);
    assign is_sfd[g] = valid & (data[8*g +: 8] == SFD_BYTE);
  end

endmodule

// File: rtl/pstrip_ctrl.sv
module pstrip_ctrl
  import pstrip_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             in_err,
  input  logic [LANES-1:0] is_pre,
  input  logic [LANES-1:0] is_sfd,
  output logic             open_even,
  output logic             open_odd,
  output logic             body_beat,
  output logic             body_odd,
  output logic             beat_end
);

  pstrip_state_e state_q, state_d, after_end;
  logic          odd_q, odd_d, odd_en;
  logic          hunting, odd_hit, even_hit, all_pre;

  always_comb begin
    hunting   = (state_q == ST_IDLE) || (state_q == ST_HUNT);
    beat_end  = in_last | in_err;
    odd_hit   = (LANES > 1) && is_sfd[0];
    if (LANES == 1) even_hit = is_sfd[0];
    else            even_hit = !is_sfd[0] && is_pre[0] && is_sfd[LANES-1];
    all_pre   = &is_pre;
    after_end = in_last ? ST_IDLE : ST_DROP;

    open_even = hunting & even_hit;
    open_odd  = hunting & odd_hit;
    body_beat = (state_q == ST_BODY) & in_valid;
    body_odd  = odd_q;
  end

  always_comb begin
    state_d = state_q;
    odd_d   = odd_q;
    odd_en  = 1'b0;
    if (in_valid) begin
      unique case (state_q)
        ST_IDLE, ST_HUNT: begin
          if (even_hit || odd_hit) begin
            state_d = beat_end ? after_end : ST_BODY;
            odd_d   = odd_hit;
            odd_en  = 1'b1;
          end else if (all_pre && !beat_end) begin
            state_d = ST_HUNT;
          end else begin
            state_d = after_end;
          end
        end
        ST_BODY: begin
          if (beat_end) state_d = after_end;
        end
        ST_DROP: begin
          if (in_last) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      odd_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (odd_en) odd_q <= odd_d;
    end
  end

  // R5: once discarding, only the end of the input frame leaves DROP
  a_r5_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DROP && in_valid && !in_last) |=> (state_q == ST_DROP));

  // R12: every input frame end returns the control to IDLE
  a_r12_last_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> (state_q == ST_IDLE));

  // R2: the body is entered only on a beat that carried the delimiter
  a_r2_body_on_sfd: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BODY && $past(state_q) != ST_BODY) |-> $past(|is_sfd));

endmodule

// File: rtl/pstrip_align.sv
module pstrip_align #(
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [8*LANES-1:0] in_data,
  input  logic               in_err,
  input  logic               open_even,
  input  logic               open_odd,
  input  logic               body_beat,
  input  logic               body_odd,
  input  logic               beat_end,
  output logic               out_valid,
  output logic [8*LANES-1:0] out_data,
  output logic [LANES-1:0]   out_be,
  output logic               out_sof,
  output logic               out_eof,
  output logic               out_err
);

  localparam int DW = 8 * LANES;
  localparam logic [LANES-1:0] BE_ALL = '1;
  localparam logic [LANES-1:0] BE_LOW = LANES'(1);

  logic [7:0]       hold_q, upper_byte;
  logic             hold_en;
  logic             flush_q, flush_d;
  logic             ferr_q, ferr_d, ferr_en;
  logic             sof_q, sof_d;
  logic [DW-1:0]    odd_word, flush_word;

  logic             v_d, sof_o_d, eof_d, err_d;
  logic [DW-1:0]    data_d;
  logic [LANES-1:0] be_d;

  if (LANES > 1) begin : g_wide
    assign upper_byte = in_data[DW-1 -: 8];
    assign odd_word   = {in_data[DW-9:0], hold_q};
    assign flush_word = {{(DW-8){1'b0}}, hold_q};
  end else begin : g_narrow
    assign upper_byte = in_data;
    assign odd_word   = in_data;
    assign flush_word = hold_q;
  end

  always_comb begin
    v_d     = 1'b0;
    data_d  = '0;
    be_d    = '0;
    sof_o_d = 1'b0;
    eof_d   = 1'b0;
    err_d   = 1'b0;
    hold_en = 1'b0;
    flush_d = 1'b0;
    ferr_d  = ferr_q;
    ferr_en = 1'b0;
    sof_d   = sof_q;

    // Closing half-word of a realigned frame.
    if (flush_q) begin
      v_d     = 1'b1;
      data_d  = flush_word;
      be_d    = BE_LOW;
      sof_o_d = sof_q;
      eof_d   = 1'b1;
      err_d   = ferr_q;
      sof_d   = 1'b0;
    end

    if (body_beat) begin
      v_d     = 1'b1;
      be_d    = BE_ALL;
      sof_o_d = sof_q;
      sof_d   = 1'b0;
      if (!body_odd) begin
        data_d = in_data;
        eof_d  = beat_end;
        err_d  = in_err;
      end else begin
        data_d  = odd_word;
        hold_en = 1'b1;
        flush_d = beat_end;
        ferr_d  = in_err;
        ferr_en = beat_end;
      end
    end

    // A new frame may open in the same cycle as the previous flush.
    if (open_odd) begin
      hold_en = 1'b1;
      sof_d   = 1'b1;
      flush_d = beat_end;
      ferr_d  = in_err;
      ferr_en = beat_end;
    end
    if (open_even) sof_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      flush_q <= 1'b0;
      ferr_q  <= 1'b0;
      sof_q   <= 1'b0;
    end else begin
      if (hold_en) hold_q <= upper_byte;
      if (ferr_en) ferr_q <= ferr_d;
      flush_q <= flush_d;
      sof_q   <= sof_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_be    <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= v_d;
      if (v_d) begin
        out_data <= data_d;
        out_be   <= be_d;
        out_sof  <= sof_o_d;
        out_eof  <= eof_d;
        out_err  <= err_d;
      end
    end
  end

  // R7: only the final beat of a frame may leave a lane disabled
  a_r7_partial_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_be != BE_ALL) |-> out_eof);

  // R9: an error beat always closes the output frame
  a_r9_err_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> out_eof);

  // R10: the closing half-word never competes with a body beat
  a_r10_flush_alone: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> !body_beat);

  // R10: a pending close is emitted on the very next beat
  a_r10_flush_emits: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> (out_valid && out_eof && out_be == BE_LOW));

endmodule

// File: rtl/preamble_strip.sv
module preamble_strip #(
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [8*LANES-1:0] in_data,
  input  logic               in_last,
  input  logic               in_err,
  output logic               out_valid,
  output logic [8*LANES-1:0] out_data,
  output logic [LANES-1:0]   out_be,
  output logic               out_sof,
  output logic               out_eof,
  output logic               out_err
);

  logic             rst_sync_n;
  logic [LANES-1:0] is_pre, is_sfd;
  logic             open_even, open_odd, body_beat, body_odd, beat_end;

  pstrip_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pstrip_lane_match #(.LANES(LANES)) u_match (
    .valid  (in_valid),
    .data   (in_data),
    .is_pre (is_pre),
    .is_sfd (is_sfd)
  );

  pstrip_ctrl #(.LANES(LANES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_err    (in_err),
    .is_pre    (is_pre),
    .is_sfd    (is_sfd),
    .open_even (open_even),
    .open_odd  (open_odd),
    .body_beat (body_beat),
    .body_odd  (body_odd),
    .beat_end  (beat_end)
  );

  pstrip_align #(.LANES(LANES)) u_align (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_data   (in_data),
    .in_err    (in_err),
    .open_even (open_even),
    .open_odd  (open_odd),
    .body_beat (body_beat),
    .body_odd  (body_odd),
    .beat_end  (beat_end),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_be    (out_be),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .out_err   (out_err)
  );

endmodule

// File: tb/preamble_strip_tb.sv
`timescale 1ns/1ps
module preamble_strip_tb;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        w_iv, w_il, w_ie;
  logic [15:0] w_id;
  logic        w_ov, w_osof, w_oeof, w_oerr;
  logic [15:0] w_od;
  logic [1:0]  w_obe;
  logic        n_iv, n_il, n_ie;
  logic [7:0]  n_id;
  logic        n_ov, n_osof, n_oeof, n_oerr;
  logic [7:0]  n_od;
  logic [0:0]  n_obe;

  preamble_strip #(.LANES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(w_iv), .in_data(w_id), .in_last(w_il),
    .in_err(w_ie), .out_valid(w_ov), .out_data(w_od), .out_be(w_obe),
    .out_sof(w_osof), .out_eof(w_oeof), .out_err(w_oerr));

  preamble_strip #(.LANES(1)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .in_valid(n_iv), .in_data(n_id), .in_last(n_il),
    .in_err(n_ie), .out_valid(n_ov), .out_data(n_od), .out_be(n_obe),
    .out_sof(n_osof), .out_eof(n_oeof), .out_err(n_oerr));

  typedef struct {
    logic [15:0] d;
    logic [1:0]  be;
    logic        sof, eof, err;
  } beat_t;

  beat_t q16[$];
  beat_t q8[$];
  string t16[$];
  string t8[$];
  string cur_tag = "R1";
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cmp(input beat_t e, input string tag, input logic [15:0] d,
                     input logic [1:0] be, input logic sof, input logic eof, input logic err);
    logic [15:0] m;
    m = {{8{e.be[1]}}, {8{e.be[0]}}};
    chk((d & m) == (e.d & m), tag, "data", {16'h0, d & m}, {16'h0, e.d & m});
    chk(be == e.be, tag, "byte enable", {30'h0, be}, {30'h0, e.be});
    chk({sof, eof, err} == {e.sof, e.eof, e.err}, {tag, "/R8"}, "sof/eof/err",
        {29'h0, sof, eof, err}, {29'h0, e.sof, e.eof, e.err});
  endtask

  // Compared on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (w_ov) begin
        if (q16.size() == 0) chk(1'b0, cur_tag, "unexpected 16-bit beat", {16'h0, w_od}, 32'h0);
        else cmp(q16.pop_front(), t16.pop_front(), w_od, w_obe, w_osof, w_oeof, w_oerr);
      end
      if (n_ov) begin
        if (q8.size() == 0) chk(1'b0, cur_tag, "unexpected 8-bit beat", {24'h0, n_od}, 32'h0);
        else cmp(q8.pop_front(), t8.pop_front(), {8'h0, n_od}, {1'b0, n_obe}, n_osof, n_oeof, n_oerr);
      end
    end
  end

  task automatic idle(input int lanes);
    if (lanes == 2) begin w_iv = 0; w_il = 0; w_ie = 0; end
    else            begin n_iv = 0; n_il = 0; n_ie = 0; end
  endtask

  // Behavioural model plus driver for one raw input frame.
  task automatic send(input int lanes, input logic [7:0] raw[$], input int err_pos,
                      input int gap, input string tag);
    logic [7:0] s[$];
    logic [7:0] kept[$];
    int idx, sfd, nw, errw;
    beat_t b;
    s = raw;
    if (lanes == 2 && (s.size() % 2) == 1) s.push_back(8'h00);
    nw = s.size() / lanes;
    idx = 0;
    while (idx < s.size() && s[idx] == 8'h55) idx++;
    sfd = (idx < s.size() && s[idx] == 8'hD5) ? idx : -1;
    errw = (err_pos >= 0) ? err_pos / lanes : nw;
    if (sfd >= 0 && errw >= sfd / lanes)
      for (int p = sfd + 1; p < s.size() && p / lanes <= errw; p++) kept.push_back(s[p]);
    for (int i = 0; i < kept.size(); i += lanes) begin
      b.d   = {((lanes == 2 && i + 1 < kept.size()) ? kept[i+1] : 8'h00), kept[i]};
      b.be  = (lanes == 2 && i + 1 < kept.size()) ? 2'b11 : 2'b01;
      b.sof = (i == 0);
      b.eof = (i + lanes >= kept.size());
      b.err = b.eof && (err_pos >= 0);
      if (lanes == 2) begin q16.push_back(b); t16.push_back(tag); end
      else            begin q8.push_back(b);  t8.push_back(tag);  end
    end
    cur_tag = tag;
    for (int w = 0; w < nw; w++) begin
      if (lanes == 2) begin
        w_iv = 1; w_id = {s[2*w+1], s[2*w]};
        w_il = (w == nw - 1); w_ie = (err_pos >= 0) && (w == errw);
      end else begin
        n_iv = 1; n_id = s[w];
        n_il = (w == nw - 1); n_ie = (err_pos >= 0) && (w == errw);
      end
      @(posedge clk); #1;
      if (gap > 0 && (w % gap) == gap - 1 && w != nw - 1) begin
        idle(lanes);
        @(posedge clk); #1;
      end
    end
  endtask

  task automatic frame(input int lanes, input int npre, input int nbody, input int seed,
                       input int err_pos, input int gap, input string tag);
    logic [7:0] r[$];
    for (int i = 0; i < npre; i++) r.push_back(8'h55);
    r.push_back(8'hD5);
    for (int i = 0; i < nbody; i++) r.push_back(8'(seed + 29 * i));
    send(lanes, r, err_pos, gap, tag);
  endtask

  task automatic drain(input int lanes, input string tag);
    idle(lanes);
    repeat (4) @(posedge clk);
    #1;
    if (lanes == 2) chk(q16.size() == 0, tag, "beats still owed (16-bit)", q16.size(), 0);
    else            chk(q8.size() == 0,  tag, "beats still owed (8-bit)",  q8.size(),  0);
  endtask

  initial begin
    int n;
    for (n = 0; n < 150000; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r[$];
    rst_n = 0; w_iv = 0; w_il = 0; w_ie = 0; w_id = '0;
    n_iv = 0; n_il = 0; n_ie = 0; n_id = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!w_ov && !n_ov, "R1", "valid during reset", {30'h0, w_ov, n_ov}, 0);
    @(posedge clk); #1 rst_n = 1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(!w_ov && !n_ov, "R1", "valid after reset", {30'h0, w_ov, n_ov}, 0);
    @(posedge clk); #1;

    // 16-bit datapath
    frame(2, 0, 7, 8'h10, -1, 0, "R3");  drain(2, "R3");   // no preamble, lower lane
    frame(2, 7, 8, 8'h20, -1, 0, "R6");  drain(2, "R6");   // delimiter in upper lane
    frame(2, 6, 5, 8'h30, -1, 0, "R7");  drain(2, "R7");   // odd body, partial word
    frame(2, 5, 6, 8'h38, -1, 0, "R4");  drain(2, "R4");   // odd preamble count
    frame(2, 13, 10, 8'h40, -1, 0, "R2"); drain(2, "R2");  // long preamble
    // R10: back-to-back realigned frames, one-byte bodies included
    frame(2, 2, 1, 8'h50, -1, 0, "R10");
    frame(2, 0, 1, 8'h60, -1, 0, "R10");
    frame(2, 4, 3, 8'h70, -1, 0, "R10");
    frame(2, 7, 4, 8'h80, -1, 0, "R10");
    drain(2, "R10");
    // R5: partial-bit look-alikes drop the frame, then recovery
    r = {8'h55, 8'h55, 8'hD7, 8'hD5, 8'h01, 8'h02, 8'h03, 8'h04};
    send(2, r, -1, 0, "R5");
    r = {8'h55, 8'h5D, 8'h55, 8'hD5, 8'h05, 8'h06};
    send(2, r, -1, 0, "R5");
    frame(2, 2, 5, 8'h90, -1, 0, "R5");
    drain(2, "R5");
    // R12: frame ends inside the preamble
    r = {8'h55, 8'h55, 8'h55, 8'h55, 8'h55, 8'h55};
    send(2, r, -1, 0, "R12");
    frame(2, 1, 6, 8'hA0, -1, 0, "R12");
    drain(2, "R12");
    // R9: errors in aligned body, realigned body, preamble, delimiter word
    frame(2, 7, 8, 8'hB0, 11, 0, "R9"); drain(2, "R9");
    frame(2, 2, 9, 8'hB8, 6, 0, "R9");  drain(2, "R9");
    frame(2, 4, 3, 8'hC0, 1, 0, "R9");  drain(2, "R9");
    frame(2, 0, 5, 8'hC8, 0, 0, "R9");  drain(2, "R9");
    // R11: idle cycles inside frames
    frame(2, 3, 12, 8'hD0, -1, 1, "R11");
    frame(2, 6, 9, 8'hE0, -1, 2, "R11");
    drain(2, "R11");

    // 8-bit datapath
    frame(1, 0, 3, 8'h11, -1, 0, "R3"); drain(1, "R3");
    frame(1, 1, 5, 8'h21, -1, 0, "R4"); drain(1, "R4");
    frame(1, 7, 6, 8'h31, -1, 0, "R2");
    frame(1, 9, 4, 8'h41, -1, 0, "R2");
    drain(1, "R2");
    r = {8'h55, 8'h57, 8'hD5, 8'h01, 8'h02};
    send(1, r, -1, 0, "R5");
    frame(1, 3, 4, 8'h51, -1, 0, "R5");
    drain(1, "R5");
    frame(1, 2, 6, 8'h61, 5, 0, "R9");   drain(1, "R9");
    frame(1, 5, 6, 8'h71, -1, 1, "R11"); drain(1, "R11");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule